// File: doc/BRIEF.md
# Serializer/Deserializer Mode and Direction Controller

This block turns a pair of mode strap pins and a direction pin into the operating state of one end of a bidirectional serializer/deserializer link. It sets the power state and the reference-frequency range, and it chooses whether the local end sends or receives. From that state it drives the enables of the transmit path, the receive path, the parallel output drivers, the serial data driver and the word-clock hold. It also drives a tri-state control, a range code, a half-rate flag and a core reset. The analog clock generator and the pad drivers sit outside the block and only consume these controls.

When both mode pins are low, the block holds everything in reset and puts all outputs in high impedance. The clock generator stays off until a valid reference has been seen after power-down is left. Once it is on, a lock timer counts reference cycles before the transmit side is declared ready. Every direction reversal passes through a short window in which neither side drives. The inverted direction is registered out, so that a master can steer the direction of a slave.

Top module: `sdx_mode_dir_ctrl`

## Requirements
- R1: With mode_hi=0 and mode_lo=0, or with rst high, the outputs are as follows one state edge later. core_rst=1 and out_hiz=1. All path and driver enables, clk_gen_en, ser_ready, half_rate and rate_sel are 0.
- R2: Operating range codes, written as (mode_hi,mode_lo) → (rate_sel,half_rate):
  - (0,1) gives (0,0).
  - (1,0) gives (1,0).
  - (1,1) gives (2,1), the half-rate setting.
  In all three, core_rst=0 and out_hiz=0.
- R3: dir_out equals the inverse of dir_in as sampled on the previous clock edge, in every state, including reset and power-down.
- R4: In an operating mode with dir_in=1 (transmit), ser_en=1, cap_en=1, ser_oe=1 and wclk_hold_hi=1, while des_en=0 and par_oe=0.
- R5: In an operating mode with dir_in=0 (receive), des_en=1 and par_oe=1, while ser_en=0, cap_en=0, ser_oe=0 and wclk_hold_hi=0. clk_gen_en keeps its value.
- R6: A reversal of dir_in while operating gives exactly GAP_CYCLES cycles in which all path and driver enables are 0 and wclk_hold_hi=1, before the new path is enabled. ser_oe and par_oe are never 1 together.
- R7: clk_gen_en rises only once ref_active has been seen high outside power-down. After that it stays high even if ref_active drops, and only power-down or rst clears it.
- R8: With clk_gen_en high, ser_ready rises after LOCK_CYCLES cycles that have ref_tick high. It is 1 only while the transmit path is enabled. ref_tick low does not advance the count.
- R9: A change between two operating ranges restarts the lock count, so that ser_ready drops to 0 and clk_gen_en stays high.
- R10: mode_hi, mode_lo, dir_in and ref_active take effect SYNC_STAGES+1 clock edges after they change. ref_tick takes effect on the next edge.
- R11: When power-down is left, the path selected by dir_in is enabled at once, with no gap cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_lo | input | 1 | Low mode strap bit |
| mode_hi | input | 1 | High mode strap bit |
| dir_in | input | 1 | Direction request, 1 = transmit, 0 = receive |
| ref_active | input | 1 | Reference clock is toggling |
| ref_tick | input | 1 | One pulse per reference cycle, in the core clock domain |
| dir_out | output | 1 | Registered inverse of dir_in, for a slave device |
| core_rst | output | 1 | Global reset for the link core |
| out_hiz | output | 1 | Put all serial and parallel outputs in high impedance |
| ser_en | output | 1 | Transmit path enable |
| cap_en | output | 1 | Parallel input capture enable |
| ser_oe | output | 1 | Serial data driver enable |
| des_en | output | 1 | Receive path enable |
| par_oe | output | 1 | Parallel output driver enable |
| wclk_hold_hi | output | 1 | Hold the word clock output high |
| clk_gen_en | output | 1 | Clock generator enable, also the serial clock output enable |
| ser_ready | output | 1 | Lock time elapsed, transmit side may send |
| rate_sel | output | 2 | Reference range code |
| half_rate | output | 1 | Serial rate divided by two |

## Verification
The bench builds the block with SYNC_STAGES=2, LOCK_CYCLES=6 and GAP_CYCLES=2. The short lock time lets the exact cycle in which ready rises be checked, both with ref_tick held high and with it gated off. The check is repeated after a range change and after the reference is lost. A gap of two cycles shows the gap counter stepping, rather than only a one-cycle gap that a single flop could fake. The two-stage synchronizer makes the input latency a separate, checkable delay.

// File: rtl/sdx_ctrl_pkg.sv
package sdx_ctrl_pkg;

  // value equals {mode_hi, mode_lo}
  typedef enum logic [1:0] {
    MD_DOWN = 2'b00,
    MD_LOW  = 2'b01,
    MD_MID  = 2'b10,
    MD_HIGH = 2'b11
  } mode_t;

  typedef enum logic [1:0] {
    PH_OFF,
    PH_SER,
    PH_DES,
    PH_GAP
  } phase_t;

  typedef struct packed {
    logic ser_en;
    logic cap_en;
    logic ser_oe;
    logic des_en;
    logic par_oe;
    logic wclk_hold_hi;
  } path_en_t;

  localparam logic [1:0] RATE_LOW  = 2'd0;
  localparam logic [1:0] RATE_MID  = 2'd1;
  localparam logic [1:0] RATE_HIGH = 2'd2;

  function automatic path_en_t path_decode(input phase_t ph);
    path_en_t e;
    e = '0;
    case (ph)
      PH_SER: begin
        e.ser_en       = 1'b1;
        e.cap_en       = 1'b1;
        e.ser_oe       = 1'b1;
        e.wclk_hold_hi = 1'b1;
      end
      PH_DES: begin
        e.des_en = 1'b1;
        e.par_oe = 1'b1;
      end
      PH_GAP:  e.wclk_hold_hi = 1'b1;
      default: e = '0;
    endcase
    return e;
  endfunction

  function automatic logic [1:0] rate_of(input mode_t m);
    case (m)
      MD_MID:  return RATE_MID;
      MD_HIGH: return RATE_HIGH;
      default: return RATE_LOW;
    endcase
  endfunction

endpackage

// File: rtl/sdx_sync.sv
module sdx_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sdx_lock_timer.sv
module sdx_lock_timer
  import sdx_ctrl_pkg::*;
#(
  parameter int LOCK_CYCLES = 4096
) (
  input  logic  clk,
  input  logic  rst,
  input  mode_t mode,
  input  logic  ref_act,
  input  logic  ref_tick,
  output logic  clk_gen_en,
  output logic  lock_done
);

  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  mode_t         mode_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || mode == MD_DOWN) begin
      mode_q     <= MD_DOWN;
      clk_gen_en <= 1'b0;
      cnt        <= '0;
      lock_done  <= 1'b0;
    end else if (mode != mode_q) begin
      // new range (or power-up): the clock generator must lock again
      mode_q     <= mode;
      clk_gen_en <= clk_gen_en | ref_act;
      cnt        <= '0;
      lock_done  <= 1'b0;
    end else begin
      if (ref_act) clk_gen_en <= 1'b1;
      if (clk_gen_en && ref_tick && !lock_done) begin
        if (cnt == LAST) lock_done <= 1'b1;
        cnt <= CW'(cnt + 1'b1);
      end
    end
  end

endmodule

// File: rtl/sdx_dir_seq.sv
module sdx_dir_seq
  import sdx_ctrl_pkg::*;
#(
  parameter int GAP_CYCLES = 1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     pd,
  input  logic     dir_ser,
  output path_en_t en
);

  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);

  phase_t        phase, phase_d;
  logic [GW-1:0] gap, gap_d;

  always_comb begin
    phase_d = phase;
    gap_d   = gap;
    if (pd) begin
      phase_d = PH_OFF;
      gap_d   = '0;
    end else begin
      case (phase)
        PH_OFF: phase_d = dir_ser ? PH_SER : PH_DES;
        PH_SER: if (!dir_ser) begin
          phase_d = PH_GAP;
          gap_d   = '0;
        end
        PH_DES: if (dir_ser) begin
          phase_d = PH_GAP;
          gap_d   = '0;
        end
        PH_GAP: begin
          if (gap == GAP_LAST) phase_d = dir_ser ? PH_SER : PH_DES;
          else                 gap_d   = GW'(gap + 1'b1);
        end
        default: phase_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_OFF;
      gap   <= '0;
      en    <= '0;
    end else begin
      phase <= phase_d;
      gap   <= gap_d;
      en    <= path_decode(phase_d);
    end
  end

endmodule

// File: rtl/sdx_mode_dir_ctrl.sv
module sdx_mode_dir_ctrl
  import sdx_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_CYCLES = 4096,
  parameter int GAP_CYCLES  = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_lo,
  input  logic       mode_hi,
  input  logic       dir_in,
  input  logic       ref_active,
  input  logic       ref_tick,
  output logic       dir_out,
  output logic       core_rst,
  output logic       out_hiz,
  output logic       ser_en,
  output logic       cap_en,
  output logic       ser_oe,
  output logic       des_en,
  output logic       par_oe,
  output logic       wclk_hold_hi,
  output logic       clk_gen_en,
  output logic       ser_ready,
  output logic [1:0] rate_sel,
  output logic       half_rate
);

  localparam int SW = 4;

  logic [SW-1:0] pins_s;
  mode_t         mode_s;
  logic          dir_s, act_s, pd, lock_done;
  path_en_t      en;

  sdx_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({mode_hi, mode_lo, dir_in, ref_active}),
    .q   (pins_s)
  );

  assign mode_s = mode_t'(pins_s[3:2]);
  assign dir_s  = pins_s[1];
  assign act_s  = pins_s[0];
  assign pd     = (mode_s == MD_DOWN);

  sdx_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode_s),
    .ref_act    (act_s),
    .ref_tick   (ref_tick),
    .clk_gen_en (clk_gen_en),
    .lock_done  (lock_done)
  );

  sdx_dir_seq #(.GAP_CYCLES(GAP_CYCLES)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .pd      (pd),
    .dir_ser (dir_s),
    .en      (en)
  );

  // turn-around output for a slave: not reset, so it follows the pin in every state
  always_ff @(posedge clk) dir_out <= ~dir_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_rst  <= 1'b1;
      out_hiz   <= 1'b1;
      rate_sel  <= RATE_LOW;
      half_rate <= 1'b0;
    end else begin
      core_rst  <= pd;
      out_hiz   <= pd;
      rate_sel  <= rate_of(mode_s);
      half_rate <= (mode_s == MD_HIGH);
    end
  end

  assign ser_en       = en.ser_en;
  assign cap_en       = en.cap_en;
  assign ser_oe       = en.ser_oe;
  assign des_en       = en.des_en;
  assign par_oe       = en.par_oe;
  assign wclk_hold_hi = en.wclk_hold_hi;
  assign ser_ready    = lock_done & en.ser_en;

endmodule

// File: rtl/sdx_mode_dir_ctrl_chk.sv
module sdx_mode_dir_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       dir_in,
  input logic       dir_out,
  input logic       core_rst,
  input logic       out_hiz,
  input logic       ser_en,
  input logic       des_en,
  input logic       ser_oe,
  input logic       par_oe,
  input logic       clk_gen_en,
  input logic       ser_ready,
  input logic [1:0] rate_sel,
  input logic       half_rate
);

  a_r1_down_quiet: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> out_hiz && !ser_en && !des_en && !ser_oe && !par_oe && !clk_gen_en && !ser_ready);

  a_r2_half_code: assert property (@(posedge clk) disable iff (rst)
    half_rate |-> (rate_sel == 2'd2) && !out_hiz);

  a_r3_dir_inverse: assert property (@(posedge clk) disable iff (rst)
    dir_out == !$past(dir_in));

  a_r6_never_both: assert property (@(posedge clk) disable iff (rst)
    !(ser_oe && par_oe));

  a_r6_par_after_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(par_oe) |-> !$past(ser_oe));

  a_r6_ser_after_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_oe) |-> !$past(par_oe));

  a_r7_gen_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_gen_en) |-> core_rst);

  a_r8_ready_needs_gen: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_ready) |-> clk_gen_en && $past(clk_gen_en) && ser_en);

endmodule

bind sdx_mode_dir_ctrl sdx_mode_dir_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .dir_in     (dir_in),
  .dir_out    (dir_out),
  .core_rst   (core_rst),
  .out_hiz    (out_hiz),
  .ser_en     (ser_en),
  .des_en     (des_en),
  .ser_oe     (ser_oe),
  .par_oe     (par_oe),
  .clk_gen_en (clk_gen_en),
  .ser_ready  (ser_ready),
  .rate_sel   (rate_sel),
  .half_rate  (half_rate)
);

// File: tb/sdx_mode_dir_ctrl_tb.sv
`timescale 1ns/1ps
module sdx_mode_dir_ctrl_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_lo = 1'b0, mode_hi = 1'b0, dir_in = 1'b0, ref_active = 1'b0, ref_tick = 1'b1;
  logic dir_out, core_rst, out_hiz, ser_en, cap_en, ser_oe, des_en, par_oe;
  logic wclk_hold_hi, clk_gen_en, ser_ready, half_rate;
  logic [1:0] rate_sel;

  always #2.5 clk = ~clk;

  sdx_mode_dir_ctrl #(.SYNC_STAGES(2), .LOCK_CYCLES(6), .GAP_CYCLES(2)) u_dut (
    .clk(clk), .rst(rst), .mode_lo(mode_lo), .mode_hi(mode_hi), .dir_in(dir_in),
    .ref_active(ref_active), .ref_tick(ref_tick), .dir_out(dir_out), .core_rst(core_rst),
    .out_hiz(out_hiz), .ser_en(ser_en), .cap_en(cap_en), .ser_oe(ser_oe), .des_en(des_en),
    .par_oe(par_oe), .wclk_hold_hi(wclk_hold_hi), .clk_gen_en(clk_gen_en),
    .ser_ready(ser_ready), .rate_sel(rate_sel), .half_rate(half_rate)
  );

  // {core_rst,out_hiz,ser_en,cap_en,ser_oe,des_en,par_oe,wclk,gen,ready,half,rate[1:0],dir_out}
  logic [13:0] obs;
  assign obs = {core_rst, out_hiz, ser_en, cap_en, ser_oe, des_en, par_oe, wclk_hold_hi,
                clk_gen_en, ser_ready, half_rate, rate_sel, dir_out};

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [13:0] sb_v[$];
  string       sb_t[$];
  event        chk_ev;

  function automatic logic [13:0] e_pd(input logic d);
    return {1'b1, 1'b1, 9'b0, 2'b00, d};
  endfunction
  function automatic logic [13:0] e_ser(input logic [1:0] r, input logic h, input logic g,
                                        input logic rd, input logic d);
    return {2'b00, 3'b111, 2'b00, 1'b1, g, rd, h, r, d};
  endfunction
  function automatic logic [13:0] e_des(input logic [1:0] r, input logic h, input logic g,
                                        input logic d);
    return {2'b00, 3'b000, 2'b11, 1'b0, g, 1'b0, h, r, d};
  endfunction
  function automatic logic [13:0] e_gap(input logic [1:0] r, input logic h, input logic g,
                                        input logic d);
    return {2'b00, 3'b000, 2'b00, 1'b1, g, 1'b0, h, r, d};
  endfunction

  task automatic expect_v(input string tag, input logic [13:0] v);
    sb_v.push_back(v);
    sb_t.push_back(tag);
    -> chk_ev;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expectations and compares with the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (sb_v.size() > 0) begin
        logic [13:0] v;
        string t;
        v = sb_v.pop_front();
        t = sb_t.pop_front();
        total++;
        if (obs !== v) begin
          bad++;
          $display("FAIL %s: actual=%b expected=%b", t, obs, v);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    expect_v("R1 reset state", e_pd(1'b1));
    rst = 1'b0;
    step(3);
    expect_v("R1 power-down straps", e_pd(1'b1));

    // R2/R4/R10/R11: leave power-down into the low range, transmit
    mode_hi = 0; mode_lo = 1; dir_in = 1; ref_active = 1;
    step(2);
    expect_v("R10 pins not yet applied", e_pd(1'b0));
    step(1);
    expect_v("R11 R4 R2 transmit low range", e_ser(2'd0, 1'b0, 1'b1, 1'b0, 1'b0));
    step(5);
    expect_v("R8 not ready one cycle early", e_ser(2'd0, 1'b0, 1'b1, 1'b0, 1'b0));
    step(1);
    expect_v("R8 ready after lock count", e_ser(2'd0, 1'b0, 1'b1, 1'b1, 1'b0));

    // R9: range change restarts lock
    mode_hi = 1; mode_lo = 0;
    step(3);
    expect_v("R9 R2 range change drops ready", e_ser(2'd1, 1'b0, 1'b1, 1'b0, 1'b0));
    step(6);
    expect_v("R9 relock", e_ser(2'd1, 1'b0, 1'b1, 1'b1, 1'b0));

    // R6/R5: turn to receive
    dir_in = 0;
    step(2);
    expect_v("R10 R3 dir_out before path change", e_ser(2'd1, 1'b0, 1'b1, 1'b1, 1'b1));
    step(1);
    expect_v("R6 gap cycle 1", e_gap(2'd1, 1'b0, 1'b1, 1'b1));
    step(1);
    expect_v("R6 gap cycle 2", e_gap(2'd1, 1'b0, 1'b1, 1'b1));
    step(1);
    expect_v("R5 receive path", e_des(2'd1, 1'b0, 1'b1, 1'b1));

    // R6: back to transmit, lock kept
    dir_in = 1;
    step(3);
    expect_v("R6 gap on return", e_gap(2'd1, 1'b0, 1'b1, 1'b0));
    step(2);
    expect_v("R6 R8 transmit again, lock kept", e_ser(2'd1, 1'b0, 1'b1, 1'b1, 1'b0));

    // R2: half-rate range
    mode_lo = 1;
    step(3);
    expect_v("R2 half-rate range", e_ser(2'd2, 1'b1, 1'b1, 1'b0, 1'b0));

    // R7: loss of reference does not stop the generator
    ref_active = 0;
    step(3);
    expect_v("R7 generator held after loss", e_ser(2'd2, 1'b1, 1'b1, 1'b0, 1'b0));
    step(4);
    expect_v("R7 R8 lock completes without ref_active", e_ser(2'd2, 1'b1, 1'b1, 1'b1, 1'b0));

    // R1: power-down
    mode_hi = 0; mode_lo = 0;
    step(3);
    expect_v("R1 power-down from operation", e_pd(1'b0));

    // R11/R7: leave power-down into receive with no reference
    mode_lo = 1; dir_in = 0;
    step(3);
    expect_v("R11 R7 receive with no reference", e_des(2'd0, 1'b0, 1'b0, 1'b1));
    step(8);
    expect_v("R7 generator stays off", e_des(2'd0, 1'b0, 1'b0, 1'b1));
    ref_active = 1;
    step(3);
    expect_v("R7 generator starts on reference", e_des(2'd0, 1'b0, 1'b1, 1'b1));

    // R8: ref_tick gating
    mode_lo = 0;
    step(3);
    expect_v("R1 power-down again", e_pd(1'b1));
    ref_tick = 0; mode_lo = 1; dir_in = 1;
    step(3);
    expect_v("R8 transmit without ticks", e_ser(2'd0, 1'b0, 1'b1, 1'b0, 1'b0));
    step(10);
    expect_v("R8 no tick no progress", e_ser(2'd0, 1'b0, 1'b1, 1'b0, 1'b0));
    ref_tick = 1;
    step(5);
    expect_v("R8 five ticks not enough", e_ser(2'd0, 1'b0, 1'b1, 1'b0, 1'b0));
    step(1);
    expect_v("R8 sixth tick sets ready", e_ser(2'd0, 1'b0, 1'b1, 1'b1, 1'b0));

    // R1: reset while operating
    rst = 1;
    step(1);
    expect_v("R1 reset during operation", e_pd(1'b0));
    rst = 0;
    step(1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule